// File: doc/BRIEF.md
# Receive Tag-Strip Byte Unpacker

This block drains one received block from a 32-bit receive FIFO and turns it into a stream of data bytes. Every block's receive stream opens with two status bytes that the controller places ahead of the payload. The unpacker drops those two bytes and delivers only the payload. It takes each word apart starting from the least-significant byte. Once the last payload byte has been handed over, it stops. Any bytes still left in that word are thrown away, and the FIFO's next word stays where it is.

A sequencer loads the payload length, where a code of 0 stands for 256 bytes, and pulses `start_i`. The unpacker then pops words only while `fifo_nempty_i` is high. Bytes leave on a valid/ready port together with `byte_pos_o`, which counts the bytes accepted so far. When the block is complete, a one-cycle `done_o` pulse is raised and the count holds. If the FIFO stays empty for a programmable number of cycles while a word is still owed, the block parks in a fault state and raises `timeout_err_o`.

The controller uses five states. IDLE waits for a start. FETCH waits for a word and pops it. SCAN walks the lanes of the held word. DONE issues the completion pulse. FAULT holds the timeout error. The transitions are:
- IDLE→FETCH on start.
- FETCH→SCAN on a pop.
- FETCH→FAULT on timer expiry.
- SCAN→FETCH when the last lane advances and the block is not complete.
- SCAN→DONE when the block's final byte advances.
- DONE→IDLE always.
- FAULT→FETCH on start.

Top module: `rxs_tag_strip`

## Requirements
- R1: After reset, `fifo_pop_o`, `byte_valid_o`, `done_o` and `timeout_err_o` are low and `byte_pos_o` is 0.
- R2: A `blk_len_i` value of 1 to 255 means that many payload bytes. A value of 0 means 256 payload bytes.
- R3: The stream is read least-significant byte first within each word. Stream bytes 0 and 1 are dropped. Stream bytes 2 through len+1 appear on `byte_data_o` in order.
- R4: `fifo_pop_o` is high only while `fifo_nempty_i` is high. A block pops exactly ceil((len+2)/4) words.
- R5: While `byte_valid_o` is high and `byte_ready_i` is low, the valid signal and `byte_data_o` hold unchanged into the next cycle.
- R6: Once byte len+1 of the stream has been taken, the remaining lanes of that word are discarded and no further word is popped for the block.
- R7: `done_o` is high for exactly one cycle, the cycle after the last payload byte is accepted.
- R8: `byte_pos_o` is 0 after an accepted start. While a byte is offered, it equals that byte's 0-based index. It reaches len when the block completes and holds that value until the next accepted start.
- R9: If `fifo_nempty_i` stays low for `tmo_limit_i` consecutive cycles while a word is awaited, `timeout_err_o` rises the cycle after the last of them and stays high until a start. A limit of 0 disables the timer.
- R10: A `start_i` pulse while a block is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a block (accepted in IDLE or FAULT) |
| blk_len_i | input | 8 | Payload length, 0 codes 256 |
| tmo_limit_i | input | 16 | Empty-FIFO cycles allowed before fault, 0 disables |
| fifo_nempty_i | input | 1 | Receive FIFO holds a word |
| fifo_word_i | input | 32 | Head word of the receive FIFO (show-ahead) |
| fifo_pop_o | output | 1 | Consume the head word at this edge |
| byte_valid_o | output | 1 | Payload byte offered |
| byte_ready_i | input | 1 | Consumer takes the offered byte |
| byte_data_o | output | 8 | Payload byte |
| byte_pos_o | output | 9 | Payload bytes accepted so far |
| done_o | output | 1 | One-cycle block-complete pulse |
| timeout_err_o | output | 1 | FIFO starvation fault |

## Verification
The bench sweeps payload lengths from 1 to 12. This range covers every alignment of the two dropped bytes and the final partial word. It also runs the 253 to 256 lengths, including the zero code. Any error in the lane pointer or the byte total would show up as a shifted, missing or extra byte. Other faults it looks for are a popped word that belongs to the next block, a done pulse that arrives a cycle off or lasts two cycles, and a position count that moves after completion. Runs with stalled consumers and gapped FIFO data check that offered bytes hold. A mid-block start must not restart the count. The timeout is checked for the exact expiry cycle and for being disabled by a zero limit.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SCAN,
        ST_DONE,
        ST_FAULT
    } rxs_state_e;

    // status bytes prefixed to every received block
    localparam int unsigned TAG_BYTES = 2;

endpackage

// File: rtl/rxs_len_decode.sv
module rxs_len_decode #(
    parameter  int unsigned MAX_LEN   = 256,
    parameter  int unsigned TAG_BYTES = 2,
    localparam int unsigned LEN_W     = $clog2(MAX_LEN),
    localparam int unsigned POS_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned CNT_W     = $clog2(MAX_LEN + TAG_BYTES + 1)
) (
    input  logic [LEN_W-1:0] len_code_i,
    output logic [POS_W-1:0] data_len_o,
    output logic [CNT_W-1:0] stream_len_o
);

    always_comb begin
        if (len_code_i == '0) begin
            data_len_o = POS_W'(MAX_LEN);
        end else begin
            data_len_o = POS_W'(len_code_i);
        end
        stream_len_o = CNT_W'(data_len_o) + CNT_W'(TAG_BYTES);
    end

endmodule

// File: rtl/rxs_lane_mux.sv
module rxs_lane_mux #(
    parameter  int unsigned LANES  = 4,
    parameter  int unsigned LANE_W = 8,
    localparam int unsigned SEL_W  = $clog2(LANES)
) (
    input  logic [LANES*LANE_W-1:0] word_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [LANE_W-1:0]       lane_o
);

    logic [LANE_W-1:0] lanes [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lanes[g] = word_i[g*LANE_W +: LANE_W];
        end
    endgenerate

    assign lane_o = lanes[sel_i];

endmodule

// File: rtl/rxs_stall_timer.sv
module rxs_stall_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);

    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!stall_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = stall_i && (limit_i != '0) && ((cnt_q + 1'b1) == limit_i);

endmodule

// File: rtl/rxs_tag_strip.sv
module rxs_tag_strip
    import rxs_pkg::*;
#(
    parameter  int unsigned MAX_LEN    = 256,
    parameter  int unsigned WORD_BYTES = 4,
    parameter  int unsigned TMO_W      = 16,
    localparam int unsigned LEN_W      = $clog2(MAX_LEN),
    localparam int unsigned POS_W      = $clog2(MAX_LEN + 1),
    localparam int unsigned CNT_W      = $clog2(MAX_LEN + TAG_BYTES + 1),
    localparam int unsigned LANE_W     = $clog2(WORD_BYTES),
    localparam int unsigned WORD_W     = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  blk_len_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic              fifo_nempty_i,
    input  logic [WORD_W-1:0] fifo_word_i,
    output logic              fifo_pop_o,
    output logic              byte_valid_o,
    input  logic              byte_ready_i,
    output logic [7:0]        byte_data_o,
    output logic [POS_W-1:0]  byte_pos_o,
    output logic              done_o,
    output logic              timeout_err_o
);

    localparam logic [CNT_W-1:0]  TAG_CNT   = CNT_W'(TAG_BYTES);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

    rxs_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic [CNT_W-1:0]  seen_q;
    logic [CNT_W-1:0]  total_q;
    logic [POS_W-1:0]  pos_q;

    logic [POS_W-1:0]  dec_data_len;
    logic [CNT_W-1:0]  dec_total;
    logic [7:0]        lane_byte;
    logic              tmo_expire;
    logic              take_start;
    logic              in_tag;
    logic              at_last;
    logic              lane_end;
    logic              lane_adv;
    logic              fetch_stall;

    rxs_len_decode #(
        .MAX_LEN   (MAX_LEN),
        .TAG_BYTES (TAG_BYTES)
    ) u_len (
        .len_code_i   (blk_len_i),
        .data_len_o   (dec_data_len),
        .stream_len_o (dec_total)
    );

    rxs_lane_mux #(
        .LANES  (WORD_BYTES),
        .LANE_W (8)
    ) u_mux (
        .word_i (word_q),
        .sel_i  (lane_q),
        .lane_o (lane_byte)
    );

    assign fetch_stall = (state_q == ST_FETCH) && !fifo_nempty_i;

    rxs_stall_timer #(
        .TMO_W (TMO_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall_i  (fetch_stall),
        .limit_i  (tmo_limit_i),
        .expire_o (tmo_expire)
    );

    // lane and progress decode
    assign take_start = start_i && ((state_q == ST_IDLE) || (state_q == ST_FAULT));
    assign in_tag     = seen_q < TAG_CNT;
    assign at_last    = seen_q == (total_q - 1'b1);
    assign lane_end   = lane_q == LAST_LANE;
    assign lane_adv   = (state_q == ST_SCAN) && (in_tag || byte_ready_i);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (fifo_nempty_i)   state_d = ST_SCAN;
                else if (tmo_expire) state_d = ST_FAULT;
            end
            ST_SCAN: begin
                if (lane_adv) begin
                    if (at_last)       state_d = ST_DONE;
                    else if (lane_end) state_d = ST_FETCH;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (start_i) state_d = ST_FETCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            lane_q  <= '0;
            seen_q  <= '0;
            total_q <= '0;
            pos_q   <= '0;
        end else begin
            if (take_start) begin
                total_q <= dec_total;
                seen_q  <= '0;
                pos_q   <= '0;
            end
            if (fifo_pop_o) begin
                word_q <= fifo_word_i;
                lane_q <= '0;
            end
            if (lane_adv) begin
                seen_q <= seen_q + 1'b1;
                lane_q <= lane_q + 1'b1;
                if (!in_tag) pos_q <= pos_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        fifo_pop_o    = 1'b0;
        byte_valid_o  = 1'b0;
        done_o        = 1'b0;
        timeout_err_o = 1'b0;
        unique case (state_q)
            ST_FETCH: fifo_pop_o    = fifo_nempty_i;
            ST_SCAN:  byte_valid_o  = !in_tag;
            ST_DONE:  done_o        = 1'b1;
            ST_FAULT: timeout_err_o = 1'b1;
            default: ;
        endcase
        byte_data_o = lane_byte;
        byte_pos_o  = pos_q;
    end

    logic unused_len;
    assign unused_len = ^dec_data_len;

endmodule

// File: rtl/rxs_tag_strip_chk.sv
module rxs_tag_strip_chk #(
    parameter int unsigned MAX_LEN = 256,
    parameter int unsigned POS_W   = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             fifo_nempty_i,
    input logic             fifo_pop_o,
    input logic             byte_valid_o,
    input logic             byte_ready_i,
    input logic [7:0]       byte_data_o,
    input logic [POS_W-1:0] byte_pos_o,
    input logic             done_o,
    input logic             timeout_err_o
);

    assert_pop_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> fifo_nempty_i);

    assert_no_pop_while_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_pop_o && byte_valid_o));

    assert_offer_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_pos_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(byte_valid_o && byte_ready_i) && !start_i) |=> $stable(byte_pos_o));

    assert_pos_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_pos_o <= POS_W'(MAX_LEN));

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |-> (!byte_valid_o && !fifo_pop_o && !done_o));

endmodule

bind rxs_tag_strip rxs_tag_strip_chk #(
    .MAX_LEN (MAX_LEN),
    .POS_W   (POS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .fifo_nempty_i (fifo_nempty_i),
    .fifo_pop_o    (fifo_pop_o),
    .byte_valid_o  (byte_valid_o),
    .byte_ready_i  (byte_ready_i),
    .byte_data_o   (byte_data_o),
    .byte_pos_o    (byte_pos_o),
    .done_o        (done_o),
    .timeout_err_o (timeout_err_o)
);

// File: tb/tb_rxs_tag_strip.sv
module tb_rxs_tag_strip;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  blk_len = '0;
    logic [15:0] tmo_limit = 16'd100;
    logic        fifo_nempty = 1'b0;
    logic [31:0] fifo_word = '0;
    logic        fifo_pop;
    logic        byte_valid;
    logic        byte_ready = 1'b0;
    logic [7:0]  byte_data;
    logic [8:0]  byte_pos;
    logic        done;
    logic        timeout_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxs_tag_strip dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .blk_len_i     (blk_len),
        .tmo_limit_i   (tmo_limit),
        .fifo_nempty_i (fifo_nempty),
        .fifo_word_i   (fifo_word),
        .fifo_pop_o    (fifo_pop),
        .byte_valid_o  (byte_valid),
        .byte_ready_i  (byte_ready),
        .byte_data_o   (byte_data),
        .byte_pos_o    (byte_pos),
        .done_o        (done),
        .timeout_err_o (timeout_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] sbyte(input int k, input int n);
        return 8'((k * 37 + n * 11 + 5) & 255);
    endfunction

    task automatic check_idle(input string tag);
        check(fifo_pop == 1'b0 && byte_valid == 1'b0 && done == 1'b0 &&
              timeout_err == 1'b0, "R1", {tag, " outputs idle"},
              {fifo_pop, byte_valid, done, timeout_err}, 0);
        check(byte_pos == 9'd0, "R1", {tag, " pos"}, byte_pos, 0);
    endtask

    // rmode: 0 ready always, 1 ready every other cycle
    // gmode: 0 FIFO never gapped, 1 FIFO empty every third cycle
    task automatic run_block(input int len_in, input int rmode, input int gmode,
                             input bit poke, input string req);
        int n = (len_in == 0) ? 256 : len_in;
        int total = n + 2;
        int nwords = (total + 3) / 4;
        int got = 0, bad = 0, bad_pos = 0, bad_hold = 0, pops = 0, dones = 0;
        int first_act = 0, first_exp = 0;
        bit popped = 0, held = 0, finished = 0;
        logic [7:0] held_data = '0;
        int cyc = 0;
        q.delete();
        for (int w = 0; w < nwords; w++) begin
            logic [31:0] wd = '0;
            for (int l = 0; l < 4; l++) begin
                int k = w * 4 + l;
                wd[l*8 +: 8] = (k < total) ? sbyte(k, n) : 8'(8'hE0 + l);
            end
            q.push_back(wd);
        end
        q.push_back(32'hDEAD_BEEF);
        while (!finished && cyc < 4000) begin
            @(negedge clk);
            if (popped && q.size() > 0) void'(q.pop_front());
            fifo_nempty = (q.size() > 0) && ((gmode == 0) || (cyc % 3 != 1));
            fifo_word   = (q.size() > 0) ? q[0] : 32'h0;
            byte_ready  = (rmode == 0) || (cyc % 2 == 1);
            start       = (cyc == 0) || (poke && cyc == 5);
            blk_len     = (cyc == 0) ? 8'(len_in) : 8'd1;
            #1;
            popped = fifo_pop;
            if (fifo_pop) pops++;
            if (held && !(byte_valid && byte_data == held_data)) bad_hold++;
            held = byte_valid && !byte_ready;
            held_data = byte_data;
            if (byte_valid && byte_ready) begin
                if (got >= n || byte_data !== sbyte(got + 2, n)) begin
                    if (bad == 0) begin
                        first_act = byte_data;
                        first_exp = (got < n) ? int'(sbyte(got + 2, n)) : -1;
                    end
                    bad++;
                end
                if (byte_pos != 9'(got)) bad_pos++;
                got++;
            end
            if (done) begin
                dones++;
                finished = 1;
            end
            cyc++;
        end
        start = 0;
        check(bad == 0, "R3", $sformatf("%s len %0d first wrong byte", req, len_in), first_act, first_exp);
        check(got == n, req, $sformatf("len %0d byte count", len_in), got, n);
        check(bad_pos == 0, "R8", $sformatf("len %0d pos mismatches", len_in), bad_pos, 0);
        check(bad_hold == 0, "R5", $sformatf("len %0d held offer changed", len_in), bad_hold, 0);
        check(pops == nwords, "R4", $sformatf("len %0d words popped", len_in), pops, nwords);
        check(q.size() == 1 && q[0] == 32'hDEAD_BEEF, "R6",
              $sformatf("len %0d next word left in FIFO", len_in), q.size(), 1);
        check(byte_pos == 9'(n), "R8", $sformatf("len %0d pos at done", len_in), byte_pos, n);
        @(negedge clk);
        fifo_nempty = 0;
        #1;
        check(done == 1'b0, "R7", $sformatf("len %0d done width", len_in), done, 0);
        check(byte_pos == 9'(n), "R8", $sformatf("len %0d pos held", len_in), byte_pos, n);
        check(byte_valid == 1'b0 && fifo_pop == 1'b0, "R6",
              $sformatf("len %0d quiet after done", len_in), {byte_valid, fifo_pop}, 0);
        q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int first_err;
        bit any_err;
        repeat (3) @(negedge clk);
        #1;
        check_idle("reset");
        @(negedge clk);
        rst_n = 1'b1;

        // full alignment sweep, clean and stressed
        for (int len = 1; len <= 12; len++) run_block(len, 0, 0, 0, "R3");
        for (int len = 1; len <= 12; len++) run_block(len, 1, 1, 0, "R5");
        for (int len = 253; len <= 255; len++) run_block(len, 0, 0, 0, "R2");
        run_block(0, 0, 0, 0, "R2");
        run_block(0, 1, 1, 0, "R2");

        // start while busy must not disturb the block
        run_block(9, 0, 0, 1, "R10");
        run_block(20, 1, 0, 1, "R10");

        // starvation timeout
        tmo_limit = 16'd5;
        @(negedge clk);
        start = 1; blk_len = 8'd4; fifo_nempty = 0;
        first_err = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            start = 0;
            #1;
            if (timeout_err && first_err == 0) first_err = k;
        end
        check(first_err == 6, "R9", "cycle of timeout rise", first_err, 6);
        check(timeout_err == 1'b1, "R9", "timeout held", timeout_err, 1);
        tmo_limit = 16'd100;
        run_block(3, 0, 0, 0, "R9");
        check(timeout_err == 1'b0, "R9", "fault cleared by start", timeout_err, 0);

        // zero limit disables the timer
        tmo_limit = 16'd0;
        @(negedge clk);
        start = 1; blk_len = 8'd2; fifo_nempty = 0;
        any_err = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            start = 0;
            #1;
            if (timeout_err) any_err = 1;
        end
        check(any_err == 1'b0, "R9", "disabled timer fired", any_err, 0);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check_idle("re-reset");
        rst_n = 1'b1;
        tmo_limit = 16'd100;
        run_block(7, 1, 1, 0, "R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule